// File: doc/BRIEF.md
# SDRAM Command and Bank Timing Sequencer

This block turns single-operation requests from a user port into command codes on the chip-select, row-strobe, column-strobe and write-enable pins of a four-bank SDRAM. It supports mode register writes, row opens, column reads, column writes, single-bank precharges and burst stops. It keeps an idle or open flag for each bank and counts clock cycles since each row open. A request is then granted, held back, or refused.

The minimum gaps are given in picoseconds together with the clock period, and the block rounds each one up to whole cycles when it is elaborated. These gaps are: open-to-column, open-to-open, and open-to-precharge. A request that is legal but too early gets a no-operation code on the pins and waits. The user holds the request until the accept strobe or the error strobe is seen. If a bank has stayed open for the maximum allowed time, the block precharges it on its own, and this takes priority over any request in that cycle. Refresh, power-up delays and the data path belong to other blocks.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Pin codes, given as {cs_n,ras_n,cas_n,we_n}, are: mode write 0000, open 0011, read 0101, write 0100, precharge 0010, burst stop 0110, idle 0111. Op codes on req_op are: 0 mode write, 1 open, 2 read, 3 write, 4 precharge, 5 burst stop.
- R2: A mode write is refused with req_error while any bank is open. When it is granted, sd_addr and sd_ba carry req_addr and req_bank.
- R3: The cycle after a mode write drives the idle code, and any request in that cycle waits. The earliest next command comes two cycles after the mode write.
- R4: Until the first mode write after reset, every other op is refused with req_error.
- R5: A read or write waits until TRCD cycles after the open of its bank (3 at the default parameters). sd_addr then carries only the low COL_W bits of req_addr, so bit 10 is 0.
- R6: An open waits until TRRD cycles after the previous open (2 by default).
- R7: A precharge waits until TRAS_MIN cycles after the open of its bank (6 by default). It drives sd_addr = 0 and sd_ba = the bank.
- R8: Exactly TRAS_MAX cycles after an open (15 by default), the block itself drives a precharge to that bank. Any pending request waits in that cycle with both strobes low.
- R9: A read, write or precharge to a bank that is not open, or an open to a bank that is open, is refused with req_error. The pins show the idle code and the bank state is unchanged.
- R10: req_accept is high exactly in the cycle the requested command is on the pins, and never together with req_error. A request that waits sees the idle code.
- R11: bank_active bit i is 1 from the cycle after an open of bank i until the cycle after its precharge.
- R12: While reset is asserted, the pins show the idle code, both strobes are low and every bank is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until accepted or refused |
| req_op | input | 3 | Operation code (R1) |
| req_bank | input | 2 | Target bank |
| req_addr | input | 12 | Row, column or mode value |
| req_accept | output | 1 | Requested command is on the pins this cycle |
| req_error | output | 1 | Request refused this cycle |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address pins |
| sd_ba | output | 2 | Bank address pins |
| bank_active | output | 4 | Per-bank open flag |

## Verification
The automatic precharge at the maximum open time can fall in the same cycle as a user request. The bench provokes this by opening bank 0, leaving it open, and then presenting an open of bank 2 in exactly the cycle where bank 0 reaches fifteen cycles. That cycle is judged correct only if the pins carry the precharge to bank 0 with both strobes low. The held open must then be granted in the following cycle, and a later read of bank 0 must be refused as a read of an idle bank.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    OP_MODE  = 3'd0,
    OP_OPEN  = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_PRE   = 3'd4,
    OP_STOP  = 3'd5
  } req_op_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    PIN_MODE  = 4'b0000,
    PIN_OPEN  = 4'b0011,
    PIN_READ  = 4'b0101,
    PIN_WRITE = 4'b0100,
    PIN_PRE   = 4'b0010,
    PIN_STOP  = 4'b0110,
    PIN_IDLE  = 4'b0111
  } pin_code_e;

  function automatic int unsigned ps_to_cycles(int unsigned t_ps, int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

endpackage

// File: rtl/sdram_reset_sync.sv
module sdram_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic run_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign run_n = sync_q[1];
endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
  parameter int TRCD     = 3,
  parameter int TRAS_MIN = 6,
  parameter int TRAS_MAX = 15,
  localparam int CW = $clog2(TRAS_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_i,
  input  logic close_i,
  output logic active_o,
  output logic rcd_ok_o,
  output logic ras_ok_o,
  output logic ras_due_o
);
  logic          active_q, active_d;
  logic [CW-1:0] age_q, age_d;

  always_comb begin
    active_d = active_q;
    age_d    = age_q;
    if (open_i) begin
      active_d = 1'b1;
      age_d    = CW'(1);
    end else begin
      if (close_i) active_d = 1'b0;
      if (active_q && (age_q < CW'(TRAS_MAX))) age_d = age_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      age_q    <= '0;
    end else begin
      active_q <= active_d;
      age_q    <= age_d;
    end
  end

  assign active_o  = active_q;
  assign rcd_ok_o  = active_q && (age_q >= CW'(TRCD));
  assign ras_ok_o  = active_q && (age_q >= CW'(TRAS_MIN));
  assign ras_due_o = active_q && (age_q >= CW'(TRAS_MAX));

  AST_CLOSE_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    close_i |-> (active_q && age_q >= CW'(TRAS_MIN))); // R7
  AST_CLOSE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && age_q == CW'(TRAS_MAX)) |-> close_i); // R8
  AST_OPEN_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    open_i |-> !active_q); // R9
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned CLK_PS      = 7000,
  parameter int unsigned TRCD_PS     = 20000,
  parameter int unsigned TRRD_PS     = 14000,
  parameter int unsigned TRAS_MIN_PS = 42000,
  parameter int unsigned TRAS_MAX_PS = 100000,
  parameter int          MODE_GAP    = 2,
  parameter int          NUM_BANKS   = 4,
  parameter int          ADDR_W      = 12,
  parameter int          COL_W       = 8,
  localparam int         BA_W        = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [BA_W-1:0]   req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_accept,
  output logic              req_error,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic [NUM_BANKS-1:0] bank_active
);
  localparam int TRCD     = int'(ps_to_cycles(TRCD_PS, CLK_PS));
  localparam int TRRD     = int'(ps_to_cycles(TRRD_PS, CLK_PS));
  localparam int TRAS_MIN = int'(ps_to_cycles(TRAS_MIN_PS, CLK_PS));
  localparam int TRAS_MAX = int'(ps_to_cycles(TRAS_MAX_PS, CLK_PS));
  localparam int RW       = $clog2(TRRD + 1);
  localparam int MW       = $clog2(MODE_GAP + 1);
  localparam logic [ADDR_W-1:0] COL_MASK = ADDR_W'((1 << COL_W) - 1);

  logic run_n;
  sdram_reset_sync u_rst (.clk(clk), .rst_n(rst_n), .run_n(run_n));

  logic [NUM_BANKS-1:0] open_v, close_v, active_v, rcd_ok, ras_ok, ras_due;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdram_bank_timer #(.TRCD(TRCD), .TRAS_MIN(TRAS_MIN), .TRAS_MAX(TRAS_MAX)) u_tmr (
      .clk(clk), .rst_n(run_n), .open_i(open_v[b]), .close_i(close_v[b]),
      .active_o(active_v[b]), .rcd_ok_o(rcd_ok[b]), .ras_ok_o(ras_ok[b]),
      .ras_due_o(ras_due[b]));
  end

  logic          moded_q, moded_d;
  logic [MW-1:0] gap_q, gap_d;
  logic [RW-1:0] rrd_q, rrd_d;
  logic [BA_W-1:0] due_bank;
  logic          mode_fire;
  pin_code_e     pins;

  always_comb begin
    due_bank = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (ras_due[i]) due_bank = BA_W'(i);
    end
  end

  always_comb begin
    pins       = PIN_IDLE;
    sd_addr    = '0;
    sd_ba      = '0;
    req_accept = 1'b0;
    req_error  = 1'b0;
    open_v     = '0;
    close_v    = '0;
    mode_fire  = 1'b0;
    if (!run_n) begin
      pins = PIN_IDLE;
    end else if (|ras_due) begin
      pins              = PIN_PRE;
      sd_ba             = due_bank;
      close_v[due_bank] = 1'b1;
    end else if ((gap_q == '0) && req_valid) begin
      if (req_op == OP_MODE) begin
        if (|active_v) req_error = 1'b1;
        else begin
          pins       = PIN_MODE;
          sd_addr    = req_addr;
          sd_ba      = req_bank;
          mode_fire  = 1'b1;
          req_accept = 1'b1;
        end
      end else if (!moded_q) begin
        req_error = 1'b1;
      end else begin
        unique case (req_op)
          OP_OPEN: begin
            if (active_v[req_bank]) req_error = 1'b1;
            else if (rrd_q >= RW'(TRRD)) begin
              pins             = PIN_OPEN;
              sd_addr          = req_addr;
              sd_ba            = req_bank;
              open_v[req_bank] = 1'b1;
              req_accept       = 1'b1;
            end
          end
          OP_READ, OP_WRITE: begin
            if (!active_v[req_bank]) req_error = 1'b1;
            else if (rcd_ok[req_bank]) begin
              pins       = (req_op == OP_READ) ? PIN_READ : PIN_WRITE;
              sd_addr    = req_addr & COL_MASK;
              sd_ba      = req_bank;
              req_accept = 1'b1;
            end
          end
          OP_PRE: begin
            if (!active_v[req_bank]) req_error = 1'b1;
            else if (ras_ok[req_bank]) begin
              pins              = PIN_PRE;
              sd_ba             = req_bank;
              close_v[req_bank] = 1'b1;
              req_accept        = 1'b1;
            end
          end
          OP_STOP: begin
            pins       = PIN_STOP;
            req_accept = 1'b1;
          end
          default: req_error = 1'b1;
        endcase
      end
    end
  end

  always_comb begin
    moded_d = moded_q | mode_fire;
    gap_d   = gap_q;
    rrd_d   = rrd_q;
    if (mode_fire)           gap_d = MW'(MODE_GAP - 1);
    else if (gap_q != '0)    gap_d = gap_q - MW'(1);
    if (|open_v)             rrd_d = RW'(1);
    else if (rrd_q < RW'(TRRD)) rrd_d = rrd_q + RW'(1);
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      moded_q <= 1'b0;
      gap_q   <= '0;
      rrd_q   <= RW'(TRRD);
    end else begin
      moded_q <= moded_d;
      gap_q   <= gap_d;
      rrd_q   <= rrd_d;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins;
  assign bank_active = active_v;

  AST_RW_AFTER_RCD: assert property (@(posedge clk) disable iff (!run_n)
    (pins == PIN_READ || pins == PIN_WRITE) |-> rcd_ok[sd_ba]); // R5
  AST_OPEN_SPACING: assert property (@(posedge clk) disable iff (!run_n)
    (pins == PIN_OPEN) |-> (rrd_q >= RW'(TRRD))); // R6
  AST_MODE_ALL_IDLE: assert property (@(posedge clk) disable iff (!run_n)
    (pins == PIN_MODE) |-> (bank_active == '0)); // R2
  AST_MODE_GAP: assert property (@(posedge clk) disable iff (!run_n)
    (pins == PIN_MODE) |=> (pins == PIN_IDLE)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!run_n)
    !(req_accept && req_error)); // R10
  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!run_n)
    req_accept |-> (pins != PIN_IDLE)); // R10
endmodule

// File: tb/sdram_cmd_seq_test.sv
module sdram_cmd_seq_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        v;
    logic [2:0]  op;
    logic [1:0]  bank;
    logic [11:0] addr;
    logic        acc;
    logic        err;
    logic [3:0]  pins;
    logic [11:0] eaddr;
    logic [1:0]  eba;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd2, 2'd0, 12'h000, 1'b0, 1'b1, 4'b0111, 12'h000, 2'd0, 4'd4},  // R4 read before mode
    '{1'b1, 3'd0, 2'd0, 12'h033, 1'b1, 1'b0, 4'b0000, 12'h033, 2'd0, 4'd2},  // R2 mode write
    '{1'b1, 3'd1, 2'd0, 12'h123, 1'b0, 1'b0, 4'b0111, 12'h000, 2'd0, 4'd3},  // R3 gap stall
    '{1'b1, 3'd1, 2'd0, 12'h123, 1'b1, 1'b0, 4'b0011, 12'h123, 2'd0, 4'd1},  // R1 open b0
    '{1'b1, 3'd1, 2'd1, 12'h456, 1'b0, 1'b0, 4'b0111, 12'h000, 2'd0, 4'd6},  // R6 stall
    '{1'b1, 3'd1, 2'd1, 12'h456, 1'b1, 1'b0, 4'b0011, 12'h456, 2'd1, 4'd6},  // R6 open b1
    '{1'b1, 3'd2, 2'd0, 12'h5AB, 1'b1, 1'b0, 4'b0101, 12'h0AB, 2'd0, 4'd5},  // R5 read b0
    '{1'b1, 3'd3, 2'd1, 12'h7FF, 1'b0, 1'b0, 4'b0111, 12'h000, 2'd0, 4'd5},  // R5 write stall
    '{1'b1, 3'd3, 2'd1, 12'h7FF, 1'b1, 1'b0, 4'b0100, 12'h0FF, 2'd1, 4'd5},  // R5 write b1
    '{1'b1, 3'd4, 2'd1, 12'hFFF, 1'b0, 1'b0, 4'b0111, 12'h000, 2'd0, 4'd7},  // R7 stall
    '{1'b1, 3'd4, 2'd1, 12'hFFF, 1'b0, 1'b0, 4'b0111, 12'h000, 2'd0, 4'd7},  // R7 stall
    '{1'b1, 3'd4, 2'd1, 12'hFFF, 1'b1, 1'b0, 4'b0010, 12'h000, 2'd1, 4'd7},  // R7 precharge b1
    '{1'b1, 3'd0, 2'd0, 12'h021, 1'b0, 1'b1, 4'b0111, 12'h000, 2'd0, 4'd2},  // R2 mode refused
    '{1'b1, 3'd4, 2'd1, 12'h000, 1'b0, 1'b1, 4'b0111, 12'h000, 2'd0, 4'd9},  // R9 pre idle bank
    '{1'b1, 3'd1, 2'd0, 12'h222, 1'b0, 1'b1, 4'b0111, 12'h000, 2'd0, 4'd9},  // R9 open open bank
    '{1'b1, 3'd5, 2'd0, 12'h000, 1'b1, 1'b0, 4'b0110, 12'h000, 2'd0, 4'd1},  // R1 burst stop
    '{1'b0, 3'd0, 2'd0, 12'h000, 1'b0, 1'b0, 4'b0111, 12'h000, 2'd0, 4'd10}, // R10 no request
    '{1'b0, 3'd0, 2'd0, 12'h000, 1'b0, 1'b0, 4'b0111, 12'h000, 2'd0, 4'd10}, // R10 no request
    '{1'b1, 3'd1, 2'd2, 12'h0F0, 1'b0, 1'b0, 4'b0010, 12'h000, 2'd0, 4'd8},  // R8 forced precharge
    '{1'b1, 3'd1, 2'd2, 12'h0F0, 1'b1, 1'b0, 4'b0011, 12'h0F0, 2'd2, 4'd8},  // R8 held open granted
    '{1'b1, 3'd2, 2'd0, 12'h010, 1'b0, 1'b1, 4'b0111, 12'h000, 2'd0, 4'd9}   // R9 read closed b0
  };

  logic clk, rst_n, req_valid, req_accept, req_error;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [2:0]  req_op;
  logic [1:0]  req_bank, sd_ba;
  logic [11:0] req_addr, sd_addr;
  logic [3:0]  bank_active;
  int n_chk, n_bad;
  bit done;

  sdram_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_addr(req_addr), .req_accept(req_accept),
    .req_error(req_error), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
    .bank_active(bank_active));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] b,
                       input logic [11:0] a);
    req_valid = v; req_op = op; req_bank = b; req_addr = a;
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    drive(1'b1, 3'd0, 2'd0, 12'h033);
    repeat (3) @(negedge clk);
    #1;
    // R12 reset state while a request is presented
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !req_accept && !req_error,
          "R12", "pins/strobes", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_accept, req_error}, 6'b011100);
    check(bank_active == 4'b0, "R12", "bank_active", bank_active, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].v, VEC[i].op, VEC[i].bank, VEC[i].addr);
      #1;
      check({req_accept, req_error, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} ==
            {VEC[i].acc, VEC[i].err, VEC[i].pins},
            $sformatf("R%0d", VEC[i].rq), $sformatf("vector %0d acc/err/pins", i),
            {req_accept, req_error, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n},
            {VEC[i].acc, VEC[i].err, VEC[i].pins});
      if (VEC[i].pins != 4'b0111)
        check({sd_addr, sd_ba} == {VEC[i].eaddr, VEC[i].eba},
              $sformatf("R%0d", VEC[i].rq), $sformatf("vector %0d addr/ba", i),
              {sd_addr, sd_ba}, {VEC[i].eaddr, VEC[i].eba});
    end

    // R11 only bank 2 open after the walk
    @(negedge clk);
    drive(1'b0, 3'd0, 2'd0, 12'h000);
    #1;
    check(bank_active == 4'b0100, "R11", "bank_active", bank_active, 4'b0100);

    // R12 reset mid-operation closes every bank
    rst_n = 1'b0;
    drive(1'b1, 3'd1, 2'd3, 12'h001);
    #1;
    check(bank_active == 4'b0 && !req_accept && sd_cs_n == 1'b0 && sd_ras_n == 1'b1,
          "R12", "state in reset", {bank_active, req_accept, sd_ras_n}, 6'b000001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    drive(1'b1, 3'd1, 2'd3, 12'h001);
    #1;
    // R4 mode must be rewritten after reset
    check(req_error && !req_accept, "R4", "open after reset", {req_accept, req_error}, 2'b01);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule